// File: doc/BRIEF.md
# DMA Transfer Byte Counter

This block holds the number of bytes still to move in a block-move transfer of a bus-mastering DMA engine. The count is a 24-bit down-counter. It can be loaded in three ways: from the host through a byte-enabled register write, from the low 24 bits of a fetched instruction word, or with an offset value for table-indirect addressing. When loads coincide, a fixed priority picks one of them, and any load beats a decrement in the same cycle.

Every completed data beat on the host bus reduces the count by that beat's byte count, from 0 to 8. The transfer direction selects which beat strobe counts. On a send, the strobe for memory-to-FIFO fills counts. On a receive, the strobe for memory writes counts. A decrement larger than the remaining count stops the counter at zero and sets a sticky error.

Two single-cycle pulses report events. The done pulse marks an active block move whose count has reached exactly zero. The illegal-instruction pulse marks a block move that was loaded with a zero count, unless the device is in target mode during the command phase.

Top module: `dma_byte_counter`

## Requirements
- R1: After reset the count is 0, and `done`, `illegal_op` and `underflow_err` are low.
- R2: A host write with `host_wr` high updates count byte k (bits 8k+7..8k) from `host_wdata` only where `host_be[k]` is 1, for k = 0, 1, 2. Bytes with a clear enable are kept. `host_rdata` always shows the count zero-extended to 32 bits.
- R3: A fetch load (`fetch_ld`) places `fetch_low` into the count on the next edge. The full range up to 0xFFFFFF is accepted.
- R4: A table load (`tbl_ld`) places `tbl_offset` into the count on the next edge.
- R5: When loads coincide, the fetch load wins over the table load, and the table load wins over the host write.
- R6: A load in the same cycle as a counted beat takes effect, and the beat is discarded.
- R7: When `dir_send`=1, a `fill_beat` reduces the count by `beat_bytes` (0..8) and `wr_beat` is ignored. When `dir_send`=0, `wr_beat` counts and `fill_beat` is ignored.
- R8: A counted beat larger than the remaining count leaves the count at 0 and sets `underflow_err`. The error stays set until reset, through later loads.
- R9: `done` is high for exactly one cycle, in the cycle after a counted beat takes an active block-move count from nonzero to exactly 0. A block move becomes active when a fetch load with `fetch_bmov`=1 loads a nonzero count. It stops being active on done, on underflow, or on any other load. Without an active block move, reaching 0 gives no `done`.
- R10: `illegal_op` is high for one cycle after a fetch load with `fetch_bmov`=1 and a zero count. It stays low when `target_mode` and `cmd_phase` were both 1 in the load cycle.
- R11: A zero-count fetch load with `fetch_bmov`=0 raises no `illegal_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_be | input | 3 | Byte enables for the three count bytes |
| host_wdata | input | 24 | Host write data |
| host_rdata | output | 32 | Count, zero-extended |
| fetch_ld | input | 1 | Load from the fetched instruction word |
| fetch_low | input | 24 | Low 24 bits of the fetched word |
| fetch_bmov | input | 1 | The fetched instruction is a block move |
| tbl_ld | input | 1 | Load a table-indirect offset |
| tbl_offset | input | 24 | Offset value |
| dir_send | input | 1 | 1 = send (memory to FIFO), 0 = receive |
| fill_beat | input | 1 | Memory-to-FIFO beat completed |
| wr_beat | input | 1 | Memory-write beat completed |
| beat_bytes | input | 4 | Bytes moved in this beat, 0..8 |
| target_mode | input | 1 | Device is acting as a target |
| cmd_phase | input | 1 | Bus is in the command phase |
| count | output | 24 | Current count |
| done | output | 1 | Block-move count exhausted pulse |
| illegal_op | output | 1 | Zero-count block-move pulse |
| underflow_err | output | 1 | Sticky over-decrement error |

## Verification
The bench builds the block with its default parameters: a 24-bit count, 8 bytes per beat at most, and a 4-bit beat width. The 24-bit width lets the bench load the all-ones maximum directly and check the byte-enable merge on every count byte. The small per-beat limit lets a handful of beats drive a count to exactly zero, or past it, within a few cycles. Each of the exempt and non-exempt mode and phase combinations is applied to a zero-count block move.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_HOST  = 2'd1,
    SRC_TBL   = 2'd2,
    SRC_FETCH = 2'd3
  } ld_src_e;
endpackage

// File: rtl/dbc_load_sel.sv
module dbc_load_sel
  import dbc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int NBYTES = CNT_W / 8
) (
  input  logic              fetch_ld,
  input  logic [CNT_W-1:0]  fetch_low,
  input  logic              tbl_ld,
  input  logic [CNT_W-1:0]  tbl_offset,
  input  logic              host_wr,
  input  logic [NBYTES-1:0] host_be,
  input  logic [CNT_W-1:0]  host_wdata,
  input  logic [CNT_W-1:0]  cur,
  output ld_src_e           ld_src,
  output logic [CNT_W-1:0]  ld_val
);
  logic [CNT_W-1:0] host_merged;

  // per-byte merge of host data into the live count
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign host_merged[8*k +: 8] = host_be[k] ? host_wdata[8*k +: 8] : cur[8*k +: 8];
  end

  always_comb begin
    ld_src = SRC_NONE;
    ld_val = cur;
    if (fetch_ld) begin
      ld_src = SRC_FETCH;
      ld_val = fetch_low;
    end else if (tbl_ld) begin
      ld_src = SRC_TBL;
      ld_val = tbl_offset;
    end else if (host_wr) begin
      ld_src = SRC_HOST;
      ld_val = host_merged;
    end
  end
endmodule

// File: rtl/dbc_dec_unit.sv
module dbc_dec_unit #(
  parameter int CNT_W  = 24,
  parameter int BEAT_W = 4
) (
  input  logic              dir_send,
  input  logic              fill_beat,
  input  logic              wr_beat,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic [CNT_W-1:0]  cur,
  output logic              dec_fire,
  output logic [CNT_W-1:0]  dec_val,
  output logic              dec_under,
  output logic              dec_to_zero
);
  // returns {underflow, saturated result}
  function automatic logic [CNT_W:0] f_sub_sat(input logic [CNT_W-1:0] a,
                                               input logic [BEAT_W-1:0] b);
    logic [CNT_W-1:0] bw;
    bw = CNT_W'(b);
    if (bw > a) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, a - bw};
  endfunction

  logic [CNT_W:0] sub_res;

  assign dec_fire    = dir_send ? fill_beat : wr_beat;
  assign sub_res     = f_sub_sat(cur, beat_bytes);
  assign dec_under   = dec_fire && sub_res[CNT_W];
  assign dec_val     = sub_res[CNT_W-1:0];
  assign dec_to_zero = dec_fire && !sub_res[CNT_W] && (cur != '0) && (sub_res[CNT_W-1:0] == '0);
endmodule

// File: rtl/dbc_flag_gen.sv
module dbc_flag_gen
  import dbc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ld_src_e ld_src,
  input  logic    fetch_bmov,
  input  logic    ld_zero,
  input  logic    target_mode,
  input  logic    cmd_phase,
  input  logic    dec_fire,
  input  logic    dec_under,
  input  logic    dec_to_zero,
  output logic    done,
  output logic    illegal_op,
  output logic    underflow_err,
  output logic    bmov_active
);
  logic exempt;
  assign exempt = target_mode && cmd_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done          <= 1'b0;
      illegal_op    <= 1'b0;
      underflow_err <= 1'b0;
      bmov_active   <= 1'b0;
    end else begin
      done       <= 1'b0;
      illegal_op <= 1'b0;
      if (ld_src == SRC_FETCH) begin
        bmov_active <= fetch_bmov && !ld_zero;
        illegal_op  <= fetch_bmov && ld_zero && !exempt;
      end else if (ld_src != SRC_NONE) begin
        bmov_active <= 1'b0;
      end else if (dec_fire) begin
        done <= bmov_active && dec_to_zero;
        if (dec_to_zero || dec_under) bmov_active <= 1'b0;
        if (dec_under) underflow_err <= 1'b1;
      end
    end
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);
  assert_illegal_exempt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_src == SRC_FETCH && exempt) |=> !illegal_op);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter
  import dbc_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int HOST_W   = 32,
  parameter int MAX_BEAT = 8,
  parameter int BEAT_W   = $clog2(MAX_BEAT + 1),
  parameter int NBYTES   = CNT_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [NBYTES-1:0] host_be,
  input  logic [CNT_W-1:0]  host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              fetch_ld,
  input  logic [CNT_W-1:0]  fetch_low,
  input  logic              fetch_bmov,
  input  logic              tbl_ld,
  input  logic [CNT_W-1:0]  tbl_offset,
  input  logic              dir_send,
  input  logic              fill_beat,
  input  logic              wr_beat,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic              target_mode,
  input  logic              cmd_phase,
  output logic [CNT_W-1:0]  count,
  output logic              done,
  output logic              illegal_op,
  output logic              underflow_err
);
  localparam int PAD_W = HOST_W - CNT_W;

  ld_src_e          ld_src;
  logic [CNT_W-1:0] ld_val;
  logic             dec_fire, dec_under, dec_to_zero;
  logic [CNT_W-1:0] dec_val;
  logic             bmov_active;
  logic             ld_any;

  dbc_load_sel #(.CNT_W(CNT_W), .NBYTES(NBYTES)) u_ld (
    .fetch_ld(fetch_ld), .fetch_low(fetch_low),
    .tbl_ld(tbl_ld), .tbl_offset(tbl_offset),
    .host_wr(host_wr), .host_be(host_be), .host_wdata(host_wdata),
    .cur(count), .ld_src(ld_src), .ld_val(ld_val)
  );

  dbc_dec_unit #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_dec (
    .dir_send(dir_send), .fill_beat(fill_beat), .wr_beat(wr_beat),
    .beat_bytes(beat_bytes), .cur(count),
    .dec_fire(dec_fire), .dec_val(dec_val),
    .dec_under(dec_under), .dec_to_zero(dec_to_zero)
  );

  dbc_flag_gen u_flg (
    .clk(clk), .rst_n(rst_n), .ld_src(ld_src), .fetch_bmov(fetch_bmov),
    .ld_zero(ld_val == '0), .target_mode(target_mode), .cmd_phase(cmd_phase),
    .dec_fire(dec_fire), .dec_under(dec_under), .dec_to_zero(dec_to_zero),
    .done(done), .illegal_op(illegal_op), .underflow_err(underflow_err),
    .bmov_active(bmov_active)
  );

  assign ld_any = (ld_src != SRC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (ld_any)   count <= ld_val;
    else if (dec_fire) count <= dec_val;
  end

  assign host_rdata = {{PAD_W{1'b0}}, count};

  assert_fetch_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ld |=> count == $past(fetch_low));
  assert_tbl_over_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_ld && !fetch_ld) |=> count == $past(tbl_offset));
  assert_dec_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_any && dec_fire && !dec_under) |=> count == $past(count) - CNT_W'($past(beat_bytes)));
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_any && dec_under) |=> (count == '0) && underflow_err);
  assert_done_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> count == '0);
  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> count == '0);
endmodule

// File: tb/sim_dma_byte_counter.sv
module sim_dma_byte_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [2:0]  host_be;
  logic [23:0] host_wdata;
  logic [31:0] host_rdata;
  logic        fetch_ld, fetch_bmov, tbl_ld;
  logic [23:0] fetch_low, tbl_offset;
  logic        dir_send, fill_beat, wr_beat;
  logic [3:0]  beat_bytes;
  logic        target_mode, cmd_phase;
  logic [23:0] count;
  logic        done, illegal_op, underflow_err;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  dma_byte_counter u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_be = 0; host_wdata = 0;
    fetch_ld = 0; fetch_low = 0; fetch_bmov = 0;
    tbl_ld = 0; tbl_offset = 0;
    fill_beat = 0; wr_beat = 0; beat_bytes = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    idle(); dir_send = 1; target_mode = 0; cmd_phase = 0;
    rst_n = 0; tick(); tick(); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(count == 0, "R1 count", count, 0);
    chk({done, illegal_op, underflow_err} == 0, "R1 flags", {done, illegal_op, underflow_err}, 0);
    chk(host_rdata == 0, "R1 rdata", host_rdata, 0);
  endtask

  task automatic t_host();
    do_reset();
    host_wr = 1; host_be = 3'b111; host_wdata = 24'h123456; tick();
    chk(count == 24'h123456, "R2 full write", count, 24'h123456);
    chk(host_rdata == 32'h00123456, "R2 read", host_rdata, 32'h00123456);
    host_be = 3'b010; host_wdata = 24'hFFAB00; tick();
    chk(count == 24'h12AB56, "R2 middle byte", count, 24'h12AB56);
    host_be = 3'b101; host_wdata = 24'h77EE99; tick();
    chk(count == 24'h77AB99, "R2 outer bytes", count, 24'h77AB99);
    host_be = 3'b000; host_wdata = 24'h000000; tick();
    chk(count == 24'h77AB99, "R2 no enables", count, 24'h77AB99);
    idle(); tick();
  endtask

  task automatic t_loads();
    do_reset();
    fetch_ld = 1; fetch_low = 24'hFFFFFF; tick(); idle();
    chk(count == 24'hFFFFFF, "R3 max fetch", count, 24'hFFFFFF);
    tbl_ld = 1; tbl_offset = 24'h000400; tick(); idle();
    chk(count == 24'h000400, "R4 table load", count, 24'h000400);
    fetch_ld = 1; fetch_low = 24'h000011; tbl_ld = 1; tbl_offset = 24'h000022;
    host_wr = 1; host_be = 3'b111; host_wdata = 24'h000033; tick(); idle();
    chk(count == 24'h11, "R5 fetch wins", count, 24'h11);
    tbl_ld = 1; tbl_offset = 24'h000022; host_wr = 1; host_be = 3'b111; host_wdata = 24'h33; tick(); idle();
    chk(count == 24'h22, "R5 table over host", count, 24'h22);
    dir_send = 1; fill_beat = 1; beat_bytes = 4; tbl_ld = 1; tbl_offset = 24'h000100; tick(); idle();
    chk(count == 24'h100, "R6 load beats decrement", count, 24'h100);
    dir_send = 0; wr_beat = 1; beat_bytes = 8; host_wr = 1; host_be = 3'b001; host_wdata = 24'h50; tick(); idle();
    chk(count == 24'h150, "R6 host over decrement", count, 24'h150);
  endtask

  task automatic t_dec();
    do_reset();
    fetch_ld = 1; fetch_bmov = 1; fetch_low = 24'd20; tick(); idle();
    chk(illegal_op == 0, "R10 nonzero load", illegal_op, 0);
    dir_send = 1; fill_beat = 1; beat_bytes = 8; tick(); idle();
    chk(count == 12, "R7 send fill beat", count, 12);
    wr_beat = 1; beat_bytes = 4; tick(); idle();
    chk(count == 12, "R7 write beat ignored on send", count, 12);
    dir_send = 0; wr_beat = 1; beat_bytes = 4; tick(); idle();
    chk(count == 8, "R7 receive write beat", count, 8);
    fill_beat = 1; beat_bytes = 4; tick(); idle();
    chk(count == 8, "R7 fill beat ignored on receive", count, 8);
    wr_beat = 1; beat_bytes = 0; tick(); idle();
    chk(count == 8, "R7 zero-byte beat", count, 8);
    chk(done == 0, "R9 no early done", done, 0);
    wr_beat = 1; beat_bytes = 8; tick(); idle();
    chk(count == 0, "R9 reaches zero", count, 0);
    chk(done == 1, "R9 done pulse", done, 1);
    tick();
    chk(done == 0, "R9 done one cycle", done, 0);
  endtask

  task automatic t_under();
    do_reset();
    tbl_ld = 1; tbl_offset = 24'd8; tick(); idle();
    dir_send = 1; fill_beat = 1; beat_bytes = 8; tick(); idle();
    chk(count == 0 && done == 0, "R9 inactive no done", {count[7:0], 7'd0, done}, 0);
    host_wr = 1; host_be = 3'b111; host_wdata = 24'd3; tick(); idle();
    fill_beat = 1; beat_bytes = 5; tick(); idle();
    chk(count == 0, "R8 saturate", count, 0);
    chk(underflow_err == 1, "R8 error set", underflow_err, 1);
    chk(done == 0, "R9 no done on underflow", done, 0);
    fetch_ld = 1; fetch_bmov = 1; fetch_low = 24'd9; tick(); idle(); tick();
    chk(underflow_err == 1, "R8 sticky through load", underflow_err, 1);
  endtask

  task automatic t_illegal();
    do_reset();
    fetch_ld = 1; fetch_bmov = 1; fetch_low = 24'd0; tick(); idle();
    chk(illegal_op == 1, "R10 zero block move", illegal_op, 1);
    tick();
    chk(illegal_op == 0, "R10 single pulse", illegal_op, 0);
    target_mode = 1; cmd_phase = 1; fetch_ld = 1; fetch_bmov = 1; tick(); idle();
    chk(illegal_op == 0, "R10 exempt target command", illegal_op, 0);
    cmd_phase = 0; fetch_ld = 1; fetch_bmov = 1; tick(); idle();
    chk(illegal_op == 1, "R10 target not command", illegal_op, 1);
    target_mode = 0; cmd_phase = 1; fetch_ld = 1; fetch_bmov = 1; tick(); idle();
    chk(illegal_op == 1, "R10 initiator command", illegal_op, 1);
    fetch_ld = 1; fetch_bmov = 0; tick(); idle();
    chk(illegal_op == 0, "R11 non block move", illegal_op, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_host();
    t_loads();
    t_dec();
    t_under();
    t_illegal();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule